// File: doc/BRIEF.md
# Shift register with sign extend

An 8-bit register clocked on the rising edge. It has four synchronous modes: hold, parallel load, shift with serial entry, and shift with sign extension. In both shift modes every stage passes its value one place toward the top bit. In serial-entry mode the bottom bit takes one of two serial inputs, and a select line picks which one. In sign-extend mode the bottom bit keeps its own value, so that bit is repeated as the word moves up.

Parallel data enters and leaves over one shared bidirectional bus. The bus is modelled as three pieces: a separate input vector, an output vector that always carries the register contents, and one drive-enable flag. Pad buffers outside the block use that flag. The drive is withdrawn when the active-low output enable is high, and it is also withdrawn automatically while a parallel load is in progress, so that an external source can own the bus. A serial output is always driven and shows the top bit.

An active-low master reset clears the register asynchronously. Its release is synchronized through two flops.

Top module: `srl_sext_reg`

## Requirements
- R1: While `rst_n` is low, `io_out` is 0 and `ser_out` is 0 at once, without waiting for a clock edge, and no clocked mode changes the register.
- R2: While `en_n` is high, each rising edge leaves the register unchanged, whatever the other controls are.
- R3: With `en_n`=0 and `shift_nload`=0, a rising edge loads `io_in` into the register (bit i from `io_in[i]`).
- R4: With `en_n`=0, `shift_nload`=1 and `ser_en`=1, a rising edge moves bit i to bit i+1 for i=0..6. Bit 0 takes `ser_a` when `ser_sel`=0 and `ser_b` when `ser_sel`=1.
- R5: With `en_n`=0, `shift_nload`=1 and `ser_en`=0, a rising edge moves bit i to bit i+1 for i=0..6, and bit 0 keeps its previous value.
- R6: `io_oe` is 0 whenever `drv_n` is 1. Clocked modes still act on the register in that case.
- R7: `io_oe` is 0 whenever `en_n`=0 and `shift_nload`=0 (parallel-load mode). Otherwise it is 1 when `drv_n`=0.
- R8: `ser_out` always equals bit 7 of the register, and `io_out` always equals the register, regardless of `io_oe`.
- R9: After `rst_n` rises, the first two rising edges still leave the register cleared. The third edge is the first that acts on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous master reset, active low |
| en_n | input | 1 | Register enable, active low; high holds |
| shift_nload | input | 1 | 1 selects shift, 0 selects parallel load |
| ser_en | input | 1 | In shift: 1 selects serial entry, 0 selects sign extend |
| ser_sel | input | 1 | Serial source select: 0 picks ser_a, 1 picks ser_b |
| ser_a | input | 1 | Serial data source 0 |
| ser_b | input | 1 | Serial data source 1 |
| drv_n | input | 1 | Bus drive enable, active low |
| io_in | input | 8 | Bus value seen at the pads |
| io_out | output | 8 | Register contents toward the pads |
| io_oe | output | 1 | Pad drive enable |
| ser_out | output | 1 | Serial output, bit 7 |

## Verification
The bench starts with a hand-worked vector chain and then runs a long random sequence against a reference model, with the drive enable toggling while shifting. Several failure cases are targeted:
- A design that shifts in the wrong direction shows a wrong word after the first shift step.
- A design that extends from the wrong end, or uses the serial input in sign-extend mode, shows wrong low bits.
- A design that swaps the two serial sources fails as soon as the select line toggles.
- A design that keeps driving the bus during a load, or that lets the hold control be overridden by the load select, shows a wrong `io_oe` or a changed word.
- A design that releases reset without the two-edge delay, or that waits for a clock edge before clearing, fails the mid-shift reset test.

// File: rtl/srl_pkg.sv
package srl_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD       = 2'd0,
        MODE_LOAD       = 2'd1,
        MODE_SHIFT_SER  = 2'd2,
        MODE_SHIFT_SIGN = 2'd3
    } srl_mode_e;

endpackage

// File: rtl/srl_rst_sync.sv
module srl_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_sync_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srl_mode_dec.sv
module srl_mode_dec
    import srl_pkg::*;
(
    input  logic      en_n,
    input  logic      shift_nload,
    input  logic      ser_en,
    input  logic      drv_n,
    output srl_mode_e mode,
    output logic      bus_drive
);
    always_comb begin
        if (en_n)             mode = MODE_HOLD;
        else if (!shift_nload) mode = MODE_LOAD;
        else if (ser_en)      mode = MODE_SHIFT_SER;
        else                  mode = MODE_SHIFT_SIGN;
        bus_drive = !drv_n && (mode != MODE_LOAD);
    end
endmodule

// File: rtl/srl_ser_mux.sv
module srl_ser_mux #(
    parameter int SRC_N = 2,
    localparam int SEL_W = (SRC_N > 1) ? $clog2(SRC_N) : 1
) (
    input  logic [SRC_N-1:0] src,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_o
);
    generate
        if (SRC_N == 1) begin : g_single
            logic unused_sel;
            assign unused_sel = |sel;
            assign bit_o = src[0];
        end else begin : g_multi
            always_comb begin
                bit_o = 1'b0;
                for (int i = 0; i < SRC_N; i++) begin
                    if (sel == SEL_W'(i)) bit_o = src[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/srl_next.sv
module srl_next
    import srl_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  srl_mode_e        mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_bit,
    output logic [WIDTH-1:0] nxt
);
    always_comb begin
        unique case (mode)
            MODE_LOAD:       nxt = par_in;
            MODE_SHIFT_SER:  nxt = {cur[WIDTH-2:0], ser_bit};
            MODE_SHIFT_SIGN: nxt = {cur[WIDTH-2:0], cur[0]};
            default:         nxt = cur;
        endcase
    end
endmodule

// File: rtl/srl_sext_reg.sv
module srl_sext_reg
    import srl_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             shift_nload,
    input  logic             ser_en,
    input  logic             ser_sel,
    input  logic             ser_a,
    input  logic             ser_b,
    input  logic             drv_n,
    input  logic [WIDTH-1:0] io_in,
    output logic [WIDTH-1:0] io_out,
    output logic             io_oe,
    output logic             ser_out
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } state_t;

    state_t    st_d, st_q;
    srl_mode_e mode;
    logic      bus_drive;
    logic      ser_bit;
    logic      core_rst_n;
    logic [WIDTH-1:0] nxt;

    srl_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_sync_n (core_rst_n)
    );

    srl_mode_dec u_dec (
        .en_n        (en_n),
        .shift_nload (shift_nload),
        .ser_en      (ser_en),
        .drv_n       (drv_n),
        .mode        (mode),
        .bus_drive   (bus_drive)
    );

    srl_ser_mux #(.SRC_N(2)) u_mux (
        .src   ({ser_b, ser_a}),
        .sel   (ser_sel),
        .bit_o (ser_bit)
    );

    srl_next #(.WIDTH(WIDTH)) u_next (
        .mode    (mode),
        .cur     (st_q.data),
        .par_in  (io_in),
        .ser_bit (ser_bit),
        .nxt     (nxt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.data = nxt;
    end

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) st_q <= '0;
        else             st_q <= st_d;
    end

    assign io_out  = st_q.data;
    assign io_oe   = bus_drive;
    assign ser_out = st_q.data[WIDTH-1];
endmodule

module srl_sext_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             core_rst_n,
    input logic             en_n,
    input logic             shift_nload,
    input logic             ser_en,
    input logic             ser_sel,
    input logic             ser_a,
    input logic             ser_b,
    input logic             drv_n,
    input logic [WIDTH-1:0] io_in,
    input logic [WIDTH-1:0] io_out,
    input logic             io_oe,
    input logic             ser_out
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (io_out == '0 && !ser_out));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!core_rst_n)
        (core_rst_n && en_n) |=> $stable(io_out));

    assert_load_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
        (core_rst_n && !en_n && !shift_nload) |=> io_out == $past(io_in));

    assert_shift_ser_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
        (core_rst_n && !en_n && shift_nload && ser_en) |=>
        io_out == {$past(io_out[WIDTH-2:0]), $past(ser_sel ? ser_b : ser_a)});

    assert_shift_sign_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
        (core_rst_n && !en_n && shift_nload && !ser_en) |=>
        io_out == {$past(io_out[WIDTH-2:0]), $past(io_out[0])});

    assert_drive_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_n |-> !io_oe);

    assert_load_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !shift_nload) |-> !io_oe);

    assert_serial_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out == io_out[WIDTH-1]);
endmodule

bind srl_sext_reg srl_sext_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .core_rst_n  (core_rst_n),
    .en_n        (en_n),
    .shift_nload (shift_nload),
    .ser_en      (ser_en),
    .ser_sel     (ser_sel),
    .ser_a       (ser_a),
    .ser_b       (ser_b),
    .drv_n       (drv_n),
    .io_in       (io_in),
    .io_out      (io_out),
    .io_oe       (io_oe),
    .ser_out     (ser_out)
);

// File: tb/srl_sext_reg_test.sv
module srl_sext_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // vector: {en_n, shift_nload, ser_en, ser_sel, ser_a, ser_b, drv_n, io_in, exp_q, exp_oe}
    localparam logic [23:0] VEC [NVEC] = '{
        {7'b1110100, 8'hFF, 8'h00, 1'b1},  // hold                R2
        {7'b0000000, 8'hA5, 8'hA5, 1'b0},  // load                R3 R7
        {7'b0110100, 8'h00, 8'h4B, 1'b1},  // shift, src a=1      R4
        {7'b0111100, 8'h00, 8'h96, 1'b1},  // shift, src b=0      R4
        {7'b0100000, 8'h00, 8'h2C, 1'b1},  // sign extend         R5
        {7'b0000001, 8'h81, 8'h81, 1'b0},  // load, drive off     R3 R6
        {7'b0100001, 8'h00, 8'h03, 1'b0},  // sign extend, off    R5 R6
        {7'b0100000, 8'h00, 8'h07, 1'b1},  // sign extend         R5
        {7'b1000000, 8'h00, 8'h07, 1'b1},  // hold with load sel  R2 R7
        {7'b0111010, 8'hFF, 8'h0F, 1'b1},  // shift, src b=1      R4
        {7'b0000000, 8'h80, 8'h80, 1'b0},  // load                R3
        {7'b0110001, 8'hFF, 8'h00, 1'b0}   // shift, src a=0      R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1, shift_nload = 1'b1, ser_en = 1'b1, ser_sel = 1'b0;
    logic       ser_a = 1'b0, ser_b = 1'b0, drv_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic       io_oe, ser_out;

    int errors = 0;
    int checks = 0;
    logic [7:0] ref_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    srl_sext_reg uut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .shift_nload(shift_nload),
        .ser_en(ser_en), .ser_sel(ser_sel), .ser_a(ser_a), .ser_b(ser_b),
        .drv_n(drv_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] c, input logic [7:0] din);
        {en_n, shift_nload, ser_en, ser_sel, ser_a, ser_b, drv_n} = c;
        io_in = din;
    endtask

    function automatic logic [7:0] model(input logic [7:0] q);
        if (en_n)          return q;
        if (!shift_nload)  return io_in;
        if (ser_en)        return {q[6:0], ser_sel ? ser_b : ser_a};
        return {q[6:0], q[0]};
    endfunction

    function automatic logic model_oe();
        return !drv_n && !(!en_n && !shift_nload);
    endfunction

    initial begin
        #(CLK_PERIOD*200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // reset state
        #(CLK_PERIOD/4);
        chk("R1 reset io_out", {1'b0, io_out}, 9'h000);
        chk("R1 reset ser_out", {8'h00, ser_out}, 9'h000);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i][23:17], VEC[i][16:9]);
            #1;
            chk("R6/R7 io_oe", {8'h00, io_oe}, {8'h00, VEC[i][0]});
            @(posedge clk); #1;
            chk("R2-5 vec io_out", {1'b0, io_out}, {1'b0, VEC[i][8:1]});
            chk("R8 vec ser_out", {8'h00, ser_out}, {8'h00, VEC[i][8]});
        end

        // random run against the reference model, drive toggling during shifts
        ref_q = io_out;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            drive(7'($urandom), 8'($urandom));
            #1;
            chk("R6/R7 rnd io_oe", {8'h00, io_oe}, {8'h00, model_oe()});
            ref_q = model(ref_q);
            @(posedge clk); #1;
            chk("R2-R5 rnd io_out", {1'b0, io_out}, {1'b0, ref_q});
            chk("R8 rnd ser_out", {8'h00, ser_out}, {8'h00, ref_q[7]});
        end

        // reset in the middle of a shift
        @(negedge clk); drive(7'b0000000, 8'hFF);
        @(negedge clk); drive(7'b0100000, 8'h00);
        @(negedge clk);
        chk("R5 before reset", {1'b0, io_out}, 9'h0FF);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear io_out", {1'b0, io_out}, 9'h000);
        chk("R1 async clear ser_out", {8'h00, ser_out}, 9'h000);
        drive(7'b0000000, 8'hFF);
        @(posedge clk); #1;
        chk("R1 load ignored in reset", {1'b0, io_out}, 9'h000);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R9 first edge after release", {1'b0, io_out}, 9'h000);
        @(posedge clk); #1;
        chk("R9 second edge after release", {1'b0, io_out}, 9'h000);
        @(posedge clk); #1;
        chk("R9 third edge loads", {1'b0, io_out}, 9'h0FF);

        // drive off still shifts and serial output keeps driving
        @(negedge clk); drive(7'b0111101, 8'h00);
        #1;
        chk("R6 drive off", {8'h00, io_oe}, 9'h000);
        @(posedge clk); #1;
        chk("R6 shift while off", {1'b0, io_out}, 9'h0FE);
        chk("R8 ser_out while off", {8'h00, ser_out}, 9'h001);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule